// File: doc/BRIEF.md
# External Sync Input Qualifier

This block decides whether a switching converter runs from its own oscillator or from an externally supplied sync pulse train. It recovers the sync input into the reference-clock domain and times every rising-edge-to-rising-edge interval with a reference-clock counter. Each interval is then judged against an acceptance window tied to the chosen nominal switching frequency. The external source is adopted only after a run of consecutive in-window periods. A single bad period, or an input that stays quiet for too long, returns the block to its internal oscillator at once.

The selected clock leaves the block as a registered signal, and the block changes source only at period boundaries, so the converter never sees a truncated pulse. A flag tells the clock generator whether the external source is active. A second flag tells it whether frequency dithering must be suppressed: in sync mode, dithering stays off while the external clock drives the converter, and it also stays off after the external clock has failed and the internal oscillator has taken over. With the sync mode disabled, the block is a plain internal oscillator.

Top module: `sync_in_qualifier`

## Requirements
- R1: With the external source inactive, `clk_sel_out` is the internal oscillator. Its period in reference cycles is REF_KHZ divided by the nominal frequency, rounded to nearest (`freq_sel` 0 = 300 kHz, 1 = 400 kHz, 2 and 3 = 450 kHz). Its high phase is the period minus half the period (rounded down): 667/334 for code 0 and 500/250 for code 1 at a 200 MHz reference.
- R2: For code 0, a measured period of 567 to 800 reference cycles inclusive (250 to 353 kHz) counts as good. 801 cycles counts as bad.
- R3: For code 1, a period of 426 to 598 cycles (334 to 470 kHz) counts as good. 425 cycles counts as bad.
- R4: Codes 2 and 3 accept 378 to 531 cycles (376 to 530 kHz). 377 cycles counts as bad.
- R5: The first rising edge after enabling or after a timeout only starts a measurement. The switch to the external source requires 8 consecutive good periods (QUAL_COUNT); with fewer, `ext_active` stays 0.
- R6: An out-of-window period clears the good-period count to zero. If the external source is active, `ext_active` drops within 3 reference cycles of that edge.
- R7: If no rising edge arrives by the time the running period exceeds the window maximum, the block treats this as a failure and falls back at once. It also clears the count, and the next edge only starts a new measurement.
- R8: Going to the external source waits for the end of the current internal period, holds `clk_sel_out` low, and follows the external input from its next good rising edge. A fallback restarts the internal oscillator at the start of a high phase. No pulse on `clk_sel_out` is shorter than the shorter phase of either source.
- R9: `dither_inhibit` is 1 when sync mode is enabled and either the external source is active or a failure has occurred since sync mode was enabled. It is 0 with sync mode disabled.
- R10: With `sync_mode_en` low, and during reset, `ext_active` is 0, `dither_inhibit` is 0, and all qualification state is cleared. During reset `clk_sel_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Asynchronous external sync pulse train |
| freq_sel | input | 2 | Nominal switching frequency code |
| sync_mode_en | input | 1 | Enables locking to the external input |
| clk_sel_out | output | 1 | Selected switching clock |
| ext_active | output | 1 | 1 while the external source drives `clk_sel_out` |
| dither_inhibit | output | 1 | 1 when the clock generator must not dither |

## Verification
The handover into the external source and the failure fallback can fall on the same reference cycle. This happens when the edge that would complete the handover from the hold-low phase is itself out of window. The bench aligns its edge train to the observed internal clock phase, so that the qualifying run ends well before an internal period boundary. The following edge then arrives at a too-short interval while the block is holding low. The fallback must win: `ext_active` must never rise, and `dither_inhibit` must show the recorded failure.

// File: rtl/sync_qual_pkg.sv
// sync_qual_pkg: shared constants, state type and period arithmetic for the
// external sync qualifier. Assumes the reference clock frequency is given in
// kHz and that the settings are ordered from lowest to highest frequency.
package sync_qual_pkg;

    localparam int unsigned NSET  = 3;
    localparam int unsigned SEL_W = 2;

    localparam int unsigned FNOM_KHZ [NSET] = '{300, 400, 450};
    localparam int unsigned FMIN_KHZ [NSET] = '{250, 334, 376};
    localparam int unsigned FMAX_KHZ [NSET] = '{353, 470, 530};

    typedef enum logic [1:0] {
        SRC_INT  = 2'd0,
        SRC_PEND = 2'd1,
        SRC_HOLD = 2'd2,
        SRC_EXT  = 2'd3
    } src_state_e;

    // Shortest accepted period: ceiling of ref / fmax.
    function automatic int unsigned per_lo(int unsigned ref_khz, int unsigned idx);
        return (ref_khz + FMAX_KHZ[idx] - 1) / FMAX_KHZ[idx];
    endfunction

    // Longest accepted period: floor of ref / fmin.
    function automatic int unsigned per_hi(int unsigned ref_khz, int unsigned idx);
        return ref_khz / FMIN_KHZ[idx];
    endfunction

    // Internal oscillator period: ref / fnom rounded to nearest.
    function automatic int unsigned per_nom(int unsigned ref_khz, int unsigned idx);
        return (ref_khz + FNOM_KHZ[idx] / 2) / FNOM_KHZ[idx];
    endfunction

    // Largest accepted period over all settings, sizes the counters.
    function automatic int unsigned longest_period(int unsigned ref_khz);
        int unsigned m;
        m = 0;
        for (int unsigned k = 0; k < NSET; k++) begin
            if (per_hi(ref_khz, k) > m) m = per_hi(ref_khz, k);
        end
        return m;
    endfunction

endpackage

// File: rtl/sq_edge_sync.sv
// sq_edge_sync: brings the asynchronous sync input into the reference domain
// through two flops and flags its rising edges. Assumes the input high and
// low phases each last several reference cycles.
module sq_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic s1, s2, s3;

    // Synchronizer chain plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= async_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Recovered level and single-cycle rising-edge strobe.
    always_comb begin
        level = s2;
        rise  = s2 & ~s3;
    end
endmodule

// File: rtl/sq_period_meter.sv
// sq_period_meter: counts reference cycles between rising edges and classifies
// each completed period against the [lo_lim, hi_lim] window. A running count
// reaching hi_lim without an edge is reported as a bad period (timeout) and
// disarms the meter, so the next edge only starts a new measurement.
// Assumes hi_lim + 1 fits below the counter's all-ones value.
module sq_period_meter #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             rise,
    input  logic [CNT_W-1:0] lo_lim,
    input  logic [CNT_W-1:0] hi_lim,
    output logic             good_evt,
    output logic             bad_evt
);
    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             in_win;

    // Classify the period that ends on this edge, or a timeout with no edge.
    always_comb begin
        in_win   = (cnt >= lo_lim) && (cnt <= hi_lim);
        good_evt = enable && armed && rise && in_win;
        bad_evt  = enable && armed && ((rise && !in_win) || (!rise && (cnt >= hi_lim)));
    end

    // Period counter: restarts at 1 on each edge, saturates, disarms on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (rise) begin
            cnt   <= CNT_W'(1);
            armed <= 1'b1;
        end else begin
            if (cnt != '1) cnt <= cnt + CNT_W'(1);
            if (bad_evt) armed <= 1'b0;
        end
    end
endmodule

// File: rtl/sq_int_osc.sv
// sq_int_osc: internal switching oscillator divided from the reference clock.
// The high phase is period minus half the period. A restart returns the phase
// counter to the start of a high phase. Assumes period >= 2.
module sq_int_osc #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    input  logic             restart,
    output logic             clk_int,
    output logic             wrap
);
    logic [CNT_W-1:0] phase;

    // Phase decode: high for the first part, wrap strobe on the last cycle.
    always_comb begin
        clk_int = phase < (period - (period >> 1));
        wrap    = phase >= (period - CNT_W'(1));
    end

    // Phase counter with restart and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || wrap) phase <= '0;
        else                           phase <= phase + CNT_W'(1);
    end
endmodule

// File: rtl/sq_lock_ctrl.sv
// sq_lock_ctrl: qualification counter and source state machine.
// INT  : internal clock, counting good periods.
// PEND : qualified, waiting for the internal period to end.
// HOLD : output held low, waiting for the next good external edge.
// EXT  : following the external input.
// Any bad period wins over every other event in the same cycle.
module sq_lock_ctrl
    import sync_qual_pkg::*;
#(
    parameter int unsigned QUAL_COUNT = 8,
    parameter int unsigned QW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_en,
    input  logic          good_evt,
    input  logic          bad_evt,
    input  logic          osc_wrap,
    output src_state_e    state,
    output logic [QW-1:0] good_cnt,
    output logic          fail_seen,
    output logic          osc_restart
);
    logic leaving_ext;

    // Fallback out of HOLD or EXT restarts the internal oscillator.
    always_comb begin
        leaving_ext = (state == SRC_HOLD) || (state == SRC_EXT);
        osc_restart = leaving_ext && (bad_evt || !mode_en);
    end

    // Source state, consecutive-good counter and failure memory.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_en) begin
            state     <= SRC_INT;
            good_cnt  <= '0;
            fail_seen <= 1'b0;
        end else if (bad_evt) begin
            state     <= SRC_INT;
            good_cnt  <= '0;
            fail_seen <= 1'b1;
        end else begin
            if (good_evt && (good_cnt != QW'(QUAL_COUNT))) good_cnt <= good_cnt + QW'(1);
            unique case (state)
                SRC_INT:  if (good_evt && (good_cnt == QW'(QUAL_COUNT - 1))) state <= SRC_PEND;
                SRC_PEND: if (osc_wrap) state <= SRC_HOLD;
                SRC_HOLD: if (good_evt) state <= SRC_EXT;
                SRC_EXT:  state <= SRC_EXT;
                default:  state <= SRC_INT;
            endcase
        end
    end
endmodule

// File: rtl/sync_in_qualifier.sv
// sync_in_qualifier: top of the external sync qualifier. Selects the window
// and internal period from freq_sel, measures the external input, runs the
// source state machine and drives the registered switching clock.
// Assumes sync_in edges are at least a few reference cycles apart.
module sync_in_qualifier
    import sync_qual_pkg::*;
#(
    parameter int unsigned REF_KHZ    = 200000,
    parameter int unsigned QUAL_COUNT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic [SEL_W-1:0] freq_sel,
    input  logic             sync_mode_en,
    output logic             clk_sel_out,
    output logic             ext_active,
    output logic             dither_inhibit
);
    localparam int unsigned MAX_PER = longest_period(REF_KHZ);
    localparam int unsigned CNT_W   = $clog2(MAX_PER + 2);
    localparam int unsigned QW      = $clog2(QUAL_COUNT + 1);

    logic [SEL_W-1:0] set_idx;
    logic [CNT_W-1:0] lo_lim, hi_lim, nom_per;
    logic             ext_level, rise_evt;
    logic             good_evt, bad_evt;
    logic             clk_int, osc_wrap, osc_restart;
    logic             fail_seen;
    logic [QW-1:0]    good_cnt;
    src_state_e       state;

    // Clamp unused codes to the highest setting and look up its limits.
    always_comb begin
        set_idx = (freq_sel >= SEL_W'(NSET)) ? SEL_W'(NSET - 1) : freq_sel;
        lo_lim  = '0;
        hi_lim  = '0;
        nom_per = '0;
        for (int unsigned k = 0; k < NSET; k++) begin
            if (set_idx == SEL_W'(k)) begin
                lo_lim  = CNT_W'(per_lo(REF_KHZ, k));
                hi_lim  = CNT_W'(per_hi(REF_KHZ, k));
                nom_per = CNT_W'(per_nom(REF_KHZ, k));
            end
        end
    end

    sq_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_in),
        .level    (ext_level),
        .rise     (rise_evt)
    );

    sq_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (sync_mode_en),
        .rise     (rise_evt),
        .lo_lim   (lo_lim),
        .hi_lim   (hi_lim),
        .good_evt (good_evt),
        .bad_evt  (bad_evt)
    );

    sq_int_osc #(.CNT_W(CNT_W)) u_osc (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (nom_per),
        .restart (osc_restart),
        .clk_int (clk_int),
        .wrap    (osc_wrap)
    );

    sq_lock_ctrl #(.QUAL_COUNT(QUAL_COUNT), .QW(QW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_en     (sync_mode_en),
        .good_evt    (good_evt),
        .bad_evt     (bad_evt),
        .osc_wrap    (osc_wrap),
        .state       (state),
        .good_cnt    (good_cnt),
        .fail_seen   (fail_seen),
        .osc_restart (osc_restart)
    );

    // Output clock mux, registered so source changes never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sel_out <= 1'b0;
        end else begin
            unique case (state)
                SRC_HOLD: clk_sel_out <= 1'b0;
                SRC_EXT:  clk_sel_out <= ext_level;
                default:  clk_sel_out <= clk_int;
            endcase
        end
    end

    // Status flags toward the clock generator.
    always_comb begin
        ext_active     = (state == SRC_EXT);
        dither_inhibit = sync_mode_en && ((state == SRC_EXT) || fail_seen);
    end
endmodule

// File: rtl/sync_qual_checker.sv
// sync_qual_checker: concurrent properties for sync_in_qualifier, attached
// with bind. Observes ports and the control state of the top module.
module sync_qual_checker
    import sync_qual_pkg::*;
#(
    parameter int unsigned QUAL_COUNT = 8,
    parameter int unsigned QW         = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_mode_en,
    input logic          rise_evt,
    input logic          good_evt,
    input logic          bad_evt,
    input logic [1:0]    state,
    input logic [QW-1:0] good_cnt,
    input logic          ext_active,
    input logic          dither_inhibit
);
    // R6: a bad period while external drops the external source next cycle.
    p_fallback_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SRC_EXT && bad_evt) |=> !ext_active);

    // R6: a bad period clears the qualification count.
    p_bad_clears_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_evt |=> (good_cnt == '0));

    // R5: the external source is adopted only with a full qualification count.
    p_entry_qualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_active) |-> ($past(good_cnt) == QW'(QUAL_COUNT)));

    // R5: the count never passes its target.
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        good_cnt <= QW'(QUAL_COUNT));

    // R8: entry into the external source happens only on an external edge.
    p_entry_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_active) |-> $past(rise_evt && good_evt));

    // R10: with sync mode off the external source is released.
    p_mode_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode_en |=> !ext_active);

    // R9: a failure in sync mode inhibits dither from the next cycle on.
    p_dither_after_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode_en && bad_evt) |=> (dither_inhibit || !sync_mode_en));
endmodule

bind sync_in_qualifier sync_qual_checker #(
    .QUAL_COUNT (QUAL_COUNT),
    .QW         (QW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sync_mode_en   (sync_mode_en),
    .rise_evt       (rise_evt),
    .good_evt       (good_evt),
    .bad_evt        (bad_evt),
    .state          (state),
    .good_cnt       (good_cnt),
    .ext_active     (ext_active),
    .dither_inhibit (dither_inhibit)
);

// File: tb/tb_sync_in_qualifier.sv
`timescale 1ns/1ps
// tb_sync_in_qualifier: directed bench, one task per scenario.
module tb_sync_in_qualifier;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b0;
    logic [1:0] freq_sel = 2'd0;
    logic       sync_mode_en = 1'b0;
    logic       clk_sel_out, ext_active, dither_inhibit;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic ext_hist [1:32];

    // Pulse-width monitor on clk_sel_out.
    bit mon_on = 0;
    bit mon_clear = 0;
    int mon_min, mon_run;
    bit mon_started;
    logic mon_prev;

    always #2.5 clk = ~clk;

    sync_in_qualifier dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sync_in        (sync_in),
        .freq_sel       (freq_sel),
        .sync_mode_en   (sync_mode_en),
        .clk_sel_out    (clk_sel_out),
        .ext_active     (ext_active),
        .dither_inhibit (dither_inhibit)
    );

    always @(negedge clk) begin
        if (mon_clear) begin
            mon_min     = 1000000;
            mon_run     = 0;
            mon_started = 0;
            mon_prev    = clk_sel_out;
        end else if (mon_on) begin
            if (clk_sel_out !== mon_prev) begin
                if (mon_started && mon_run < mon_min) mon_min = mon_run;
                mon_started = 1;
                mon_run     = 1;
            end else begin
                mon_run++;
            end
            mon_prev = clk_sel_out;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Rising edge, then a full period; ext_active recorded 8 cycles after each edge.
    task automatic train(input int p, input int n);
        for (int i = 1; i <= 32; i++) ext_hist[i] = 1'b0;
        for (int i = 1; i <= n; i++) begin
            sync_in = 1'b1;
            cycles(8);
            ext_hist[i] = ext_active;
            cycles(p / 2 - 8);
            sync_in = 1'b0;
            cycles(p - p / 2);
        end
    endtask

    task automatic restart_mode(input logic [1:0] sel);
        sync_mode_en = 1'b0;
        sync_in      = 1'b0;
        cycles(20);
        freq_sel     = sel;
        sync_mode_en = 1'b1;
        cycles(5);
    endtask

    task automatic t_reset();
        cycles(10);
        check(clk_sel_out == 1'b0, "R10", "clk_sel_out in reset", clk_sel_out, 0);
        check(ext_active == 1'b0, "R10", "ext_active in reset", ext_active, 0);
        check(dither_inhibit == 1'b0, "R10", "dither_inhibit in reset", dither_inhibit, 0);
        rst_n = 1'b1;
        cycles(2);
    endtask

    // R1: internal oscillator period and high phase.
    task automatic t_internal(input logic [1:0] sel, input int exp_per, input int exp_hi);
        int per, hi;
        sync_mode_en = 1'b0;
        freq_sel = sel;
        for (int k = 0; k < 2; k++) begin
            while (clk_sel_out !== 1'b0) cycles(1);
            while (clk_sel_out !== 1'b1) cycles(1);
        end
        per = 0; hi = 0;
        while (clk_sel_out === 1'b1) begin cycles(1); per++; hi++; end
        while (clk_sel_out === 1'b0) begin cycles(1); per++; end
        check(per == exp_per, "R1", "internal period", per, exp_per);
        check(hi == exp_hi, "R1", "internal high phase", hi, exp_hi);
    endtask

    // R5, R7, R8, R9: lock after 8 good periods, then timeout fallback.
    task automatic t_lock_and_timeout();
        restart_mode(2'd0);
        check(dither_inhibit == 1'b0, "R9", "dither before any failure", dither_inhibit, 0);
        mon_clear = 1; cycles(1); mon_clear = 0; mon_on = 1;
        train(790, 10);
        check(ext_hist[9] == 1'b0, "R5", "ext after 8 good periods (still pending)", ext_hist[9], 0);
        check(ext_hist[10] == 1'b1, "R5", "ext after handover edge", ext_hist[10], 1);
        check(dither_inhibit == 1'b1, "R9", "dither while external", dither_inhibit, 1);
        check(ext_active == 1'b1, "R7", "ext before timeout", ext_active, 1);
        cycles(40);
        check(ext_active == 1'b0, "R7", "ext after timeout", ext_active, 0);
        check(dither_inhibit == 1'b1, "R9", "dither after failure", dither_inhibit, 1);
        cycles(800);
        mon_on = 0;
        check(mon_min >= 330, "R8", "shortest clk_sel_out pulse", mon_min, 330);
        train(790, 3);
        check(ext_hist[3] == 1'b0, "R7", "no lock from fresh start after timeout", ext_hist[3], 0);
    endtask

    // R6: a bad period restarts qualification and drops an active lock.
    task automatic t_bad_resets();
        restart_mode(2'd0);
        train(790, 6);
        train(500, 1);
        train(790, 10);
        begin
            int early;
            early = 0;
            for (int i = 1; i <= 9; i++) if (ext_hist[i]) early++;
            check(early == 0, "R6", "locks before count restarts", early, 0);
        end
        check(ext_hist[10] == 1'b1, "R6", "lock after 8 fresh good periods", ext_hist[10], 1);
        train(500, 2);
        check(ext_hist[1] == 1'b1, "R6", "ext on good edge", ext_hist[1], 1);
        check(ext_hist[2] == 1'b0, "R6", "ext after short period", ext_hist[2], 0);
    endtask

    task automatic t_window(input logic [1:0] sel, input int p, input bit exp_lock, input string req);
        restart_mode(sel);
        train(p, 12);
        check(ext_hist[12] == exp_lock, req, $sformatf("lock at period %0d", p), ext_hist[12], exp_lock);
    endtask

    // Handover and failure on the same edge: failure must win.
    task automatic t_hold_vs_fail();
        restart_mode(2'd1);
        while (clk_sel_out !== 1'b0) cycles(1);
        while (clk_sel_out !== 1'b1) cycles(1);
        cycles(300);
        train(500, 8);
        train(420, 1);
        train(500, 1);
        check(ext_hist[1] == 1'b0, "R8", "bad edge in hold does not hand over", ext_hist[1], 0);
        check(ext_active == 1'b0, "R6", "internal after bad edge in hold", ext_active, 0);
        check(dither_inhibit == 1'b1, "R9", "dither after bad edge in hold", dither_inhibit, 1);
    endtask

    // R10 and R9: sync mode off ignores a valid train and clears dither inhibit.
    task automatic t_mode_off();
        sync_mode_en = 1'b0;
        freq_sel = 2'd1;
        cycles(5);
        check(dither_inhibit == 1'b0, "R9", "dither with mode off", dither_inhibit, 0);
        train(500, 12);
        check(ext_hist[12] == 1'b0, "R10", "lock with mode off", ext_hist[12], 0);
        check(dither_inhibit == 1'b0, "R10", "dither with mode off after train", dither_inhibit, 0);
    endtask

    initial begin
        cycles(1);
        t_reset();
        t_internal(2'd1, 500, 250);
        t_internal(2'd0, 667, 334);
        t_lock_and_timeout();
        t_bad_resets();
        t_window(2'd0, 800, 1'b1, "R2");
        t_window(2'd0, 801, 1'b0, "R2");
        t_window(2'd1, 426, 1'b1, "R3");
        t_window(2'd1, 425, 1'b0, "R3");
        t_window(2'd3, 378, 1'b1, "R4");
        t_window(2'd3, 377, 1'b0, "R4");
        t_window(2'd2, 531, 1'b1, "R4");
        t_hold_vs_fail();
        t_mode_off();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule